// File: doc/BRIEF.md
# Cascadable Serial Bitstream Memory

This block models a serial configuration memory that feeds a stored bitstream to an FPGA-style loader, one bit per clock. It holds a small read-only bit array and an address counter. The counter is clocked by the loader's bit clock. While the device is selected, streaming is enabled and the reset/output-enable input is high, the device drives the bit at the current address onto a shared data line. Each rising clock edge moves it to the next bit.

Several devices can be chained. The active-low cascade output of one device drives the active-low select of the next. After its last bit has been consumed, a device releases the shared line and pulls its cascade output low, so the next device takes over on the following clock. Pulling the combined reset/output-enable input low returns every counter in the chain to the first bit. Holding it high leaves a finished chain finished.

Top module: `cfg_serial_rom`

## Requirements
- R1: While selected (`cs_n` low, `ser_en` high, `rst_oe_n` high, not finished), `data_en` is 1 and `data_bit` equals bit `addr` of the `INIT` parameter. Address 0 is `INIT[0]`, so the stream is sent LSB first and the first bit is present right after reset.
- R2: Each rising `dclk` edge in the selected state moves the device to the next address. After k such edges, bit k is presented.
- R3: The selected edge taken at address DEPTH-1 finishes the device. After that edge `cascade_n` is 0 and `data_en` is 0. The device then stays finished and its counter stays put on all later edges until a reset.
- R4: While `cs_n` is high, `data_en` is 0 and clock edges leave the counter unchanged. The stream resumes at the same bit once the device is selected again.
- R5: While `ser_en` is low, `data_en` is 0 and clock edges leave the counter unchanged.
- R6: A rising `dclk` edge with `rst_oe_n` low sets the counter to address 0 and clears the finished state. While `rst_oe_n` is low, `data_en` is 0 and `cascade_n` is 1 without waiting for a clock edge.
- R7: If `rst_oe_n` stays high after a device finishes, it stays finished. It does not wrap back to the first bit.
- R8: In a chain where the downstream `cs_n` is the upstream `cascade_n`, the shared line carries the upstream pattern followed at once by the downstream pattern, with no gap cycle. At no time do both devices assert `data_en`.
- R9: `data_bus` carries `data_bit` when `data_en` is 1 and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Bit clock from the loader; the state advances on its rising edge |
| rst_oe_n | input | 1 | Active-low synchronous counter reset; also output enable |
| cs_n | input | 1 | Active-low device select (upstream cascade output in a chain) |
| ser_en | input | 1 | Streaming enable; low idles the read path |
| data_bus | output | 1 | Tri-stated serial data line |
| data_bit | output | 1 | Bit currently addressed (value behind the driver) |
| data_en | output | 1 | High while this device drives the data line |
| cascade_n | output | 1 | Active-low handoff to the next device in a chain |

## Verification
Two instances are chained, each holding a distinct irregular 32-bit pattern. A stream with a wrong bit order, a skipped or repeated bit, or a late handoff therefore no longer matches the concatenated expectation. The first pass holds the device selected and pauses `ser_en` at random, which separates edge counting from plain clock counting. A second pass raises the upstream select at random, which shows that a paused device keeps its position and that the downstream device is not woken early. Directed cases reset the chain in the middle of the second pattern and after the chain has finished. They also run many extra clocks after completion, which tells a saturating counter apart from one that wraps.

// File: rtl/cfg_rom_pkg.sv
// Package for the serial bitstream memory.
// Holds the read-state encoding shared by the counter and the output stage.
package cfg_rom_pkg;

    // Read progress of one device: streaming bits, or finished and handed off.
    typedef enum logic {
        RD_STREAM = 1'b0,
        RD_DONE   = 1'b1
    } rd_state_e;

    // True when a device may drive and advance this cycle.
    function automatic logic rd_active(input logic rst_oe_n, input logic cs_n,
                                       input logic ser_en, input rd_state_e st);
        return rst_oe_n && !cs_n && ser_en && (st == RD_STREAM);
    endfunction

endpackage

// File: rtl/cfg_rom_addr_ctr.sv
// Address counter and read state for the serial bitstream memory.
// It advances one address per active rising edge. On the edge taken at the
// last address it enters RD_DONE and holds its address there until
// rst_oe_n is sampled low.
// Assumes: DEPTH >= 2; reset is synchronous to dclk and active low.
module cfg_rom_addr_ctr
    import cfg_rom_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              dclk,
    input  logic              rst_oe_n,
    input  logic              cs_n,
    input  logic              ser_en,
    output logic [ADDR_W-1:0] addr,
    output rd_state_e         state
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic active;
    logic at_last;

    // Decode whether this edge consumes a bit, and whether it is the final one.
    always_comb begin
        active  = rd_active(rst_oe_n, cs_n, ser_en, state);
        at_last = (addr == LAST_ADDR);
    end

    // Advance the address, or finish on the last bit; clear on reset.
    always_ff @(posedge dclk) begin
        if (!rst_oe_n) begin
            addr  <= '0;
            state <= RD_STREAM;
        end else if (active) begin
            if (at_last) begin
                state <= RD_DONE;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    // R2: an active edge below the last address steps by exactly one
    a_r2_step : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        (!cs_n && ser_en && state == RD_STREAM && addr != LAST_ADDR)
        |=> (addr == $past(addr) + 1'b1) && state == RD_STREAM);

    // R3: the active edge at the last address finishes the device
    a_r3_finish : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        (!cs_n && ser_en && state == RD_STREAM && addr == LAST_ADDR)
        |=> state == RD_DONE);

    // R3, R7: a finished device stays finished and holds its address
    a_r3_hold : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        (state == RD_DONE) |=> (state == RD_DONE) && $stable(addr));

    // R4: a deselected device keeps its position
    a_r4_hold_desel : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        cs_n |=> $stable(addr) && $stable(state));

    // R5: streaming disabled keeps the position
    a_r5_hold_idle : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        !ser_en |=> $stable(addr) && $stable(state));

    // R6: the first cycle after release starts from address 0, streaming
    a_r6_cleared : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        $rose(rst_oe_n) |-> (addr == '0) && state == RD_STREAM);

endmodule

// File: rtl/cfg_rom_bit_store.sv
// Read-only bit array for the serial bitstream memory.
// Its contents come from the INIT parameter, with bit 0 at address 0. A read
// is a one-hot select over all addresses followed by an OR reduction.
// Assumes: addr stays below DEPTH, which the counter guarantees.
module cfg_rom_bit_store #(
    parameter int              DEPTH  = 64,
    parameter int              ADDR_W = $clog2(DEPTH),
    parameter logic [DEPTH-1:0] INIT  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bit_out
);

    logic [DEPTH-1:0] hit;

    // One decode term per stored bit.
    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign hit[i] = (addr == ADDR_W'(i)) && INIT[i];
    end

    // Any matching set bit yields a one.
    always_comb bit_out = |hit;

endmodule

// File: rtl/cfg_rom_out_stage.sv
// Data driver and cascade output of the serial bitstream memory.
// It enables the shared-line driver only while the device is active. The
// cascade output goes low once the device is finished, and goes back high
// as soon as rst_oe_n is low.
// Assumes: a weak pull on the shared line outside this block.
module cfg_rom_out_stage
    import cfg_rom_pkg::*;
(
    input  logic      dclk,
    input  logic      rst_oe_n,
    input  logic      cs_n,
    input  logic      ser_en,
    input  rd_state_e state,
    input  logic      bit_in,
    output logic      data_en,
    output logic      data_bit,
    output logic      cascade_n
);

    // Gate the driver and form the handoff signal.
    always_comb begin
        data_en   = rd_active(rst_oe_n, cs_n, ser_en, state);
        data_bit  = bit_in;
        cascade_n = !(rst_oe_n && state == RD_DONE);
    end

    // R3, R8: a device handing off never drives at the same time
    a_r8_no_overlap : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        !cascade_n |-> !data_en);

    // R6: output enable low forces the driver off and the handoff high
    always_comb begin
        if (!rst_oe_n) begin
            a_r6_oe_off : assert (!data_en && cascade_n);
        end
    end

endmodule

// File: rtl/cfg_serial_rom.sv
// Cascadable serial bitstream memory, top level.
// It presents INIT one bit per dclk, LSB first, and hands off to the next
// device through cascade_n once its last bit is taken.
// Assumes: dclk is the loader's bit clock and the loader samples on its
// rising edge; rst_oe_n is synchronous to dclk.
module cfg_serial_rom
    import cfg_rom_pkg::*;
#(
    parameter int               DEPTH = 64,
    parameter logic [DEPTH-1:0] INIT  = '0
) (
    input  logic dclk,
    input  logic rst_oe_n,
    input  logic cs_n,
    input  logic ser_en,
    output logic data_bus,
    output logic data_bit,
    output logic data_en,
    output logic cascade_n
);

    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] addr;
    rd_state_e         state;
    logic              stored_bit;

    cfg_rom_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctr (
        .dclk     (dclk),
        .rst_oe_n (rst_oe_n),
        .cs_n     (cs_n),
        .ser_en   (ser_en),
        .addr     (addr),
        .state    (state)
    );

    cfg_rom_bit_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INIT(INIT)) u_store (
        .addr    (addr),
        .bit_out (stored_bit)
    );

    cfg_rom_out_stage u_out (
        .dclk      (dclk),
        .rst_oe_n  (rst_oe_n),
        .cs_n      (cs_n),
        .ser_en    (ser_en),
        .state     (state),
        .bit_in    (stored_bit),
        .data_en   (data_en),
        .data_bit  (data_bit),
        .cascade_n (cascade_n)
    );

    // R9: tri-state driver onto the shared line.
    assign data_bus = data_en ? data_bit : 1'bz;

    // R1: an enabled driver shows the addressed stored bit
    a_r1_bit_match : assert property (@(posedge dclk) disable iff (!rst_oe_n)
        data_en |-> (data_bit == INIT[addr]));

endmodule

// File: tb/cfg_serial_rom_tb_top.sv
// Bench: two chained devices on one shared line, a random pause pattern
// seeded once, and directed reset and saturation cases.
module cfg_serial_rom_tb_top;

    localparam int          D     = 32;
    localparam logic [D-1:0] PAT_A = 32'hC5A3_96E1;
    localparam logic [D-1:0] PAT_B = 32'h3B0F_D472;

    logic dclk = 1'b0;
    logic clr_n, sel_a_n, ser_en;
    logic bus_a, bit_a, en_a, casc_a;
    logic bus_b, bit_b, en_b, casc_b;
    int   n_tests = 0, n_fail = 0;
    int   k = 0;

    always #4 dclk = ~dclk;

    cfg_serial_rom #(.DEPTH(D), .INIT(PAT_A)) dut_i (
        .dclk(dclk), .rst_oe_n(clr_n), .cs_n(sel_a_n), .ser_en(ser_en),
        .data_bus(bus_a), .data_bit(bit_a), .data_en(en_a), .cascade_n(casc_a));

    cfg_serial_rom #(.DEPTH(D), .INIT(PAT_B)) dut_b (
        .dclk(dclk), .rst_oe_n(clr_n), .cs_n(casc_a), .ser_en(ser_en),
        .data_bus(bus_b), .data_bit(bit_b), .data_en(en_b), .cascade_n(casc_b));

    // Expected bit at stream position p of the concatenated chain.
    function automatic logic exp_bit(input int p);
        return (p < D) ? PAT_A[p] : PAT_B[p - D];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check before the rising edge,
    // then update the model for the rising edge.
    task automatic step(input logic s_n, input logic se, input logic cl, input string req);
        logic ea, eb, line;
        @(negedge dclk);
        sel_a_n = s_n; ser_en = se; clr_n = cl;
        #3;
        ea = cl && se && !s_n && (k < D);
        eb = cl && se && (k >= D) && (k < 2 * D);
        chk({req, " en_a"}, en_a, ea);
        chk({req, " en_b"}, en_b, eb);
        chk("R8 no overlap", en_a && en_b, 1'b0);
        chk({req, " casc_a"}, casc_a, !(cl && k >= D));
        chk({req, " casc_b"}, casc_b, !(cl && k >= 2 * D));
        if (ea || eb) begin
            line = en_a ? bit_a : (en_b ? bit_b : 1'b1);
            chk({req, " R1 data"}, line, exp_bit(k));
        end
        if (!cl) k = 0;
        else if (ea || eb) k++;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        sel_a_n = 1'b0; ser_en = 1'b1; clr_n = 1'b0;
        // R6: reset state
        step(1'b0, 1'b1, 1'b0, "R6 reset");
        step(1'b0, 1'b1, 1'b0, "R6 reset");
        // R1 R2 R5 R8: full chain with random streaming pauses
        while (k < 2 * D) step(1'b0, ($urandom % 4) != 0, 1'b1, "R2 R5 R8 stream");
        // R3 R7: many clocks after completion, no wrap
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b1, "R3 R7 saturate");
        // R6: reset after completion restarts from the first device
        step(1'b0, 1'b1, 1'b0, "R6 restart");
        // R4: random deselects of the upstream device
        while (k < D + 3) step(($urandom % 3) == 0, 1'b1, 1'b1, "R4 deselect");
        // R6: reset in the middle of the second pattern
        step(1'b1, 1'b1, 1'b0, "R6 mid reset");
        step(1'b0, 1'b0, 1'b1, "R5 idle after reset");
        // R1 R2: stream from the top again with pauses
        while (k < 2 * D) step(($urandom % 5) == 0, ($urandom % 5) != 0, 1'b1, "R1 R2 R4 restream");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, "R7 hold");
        // R9: the value behind each driver is reachable on its bus when enabled
        step(1'b0, 1'b1, 1'b0, "R6 final");
        step(1'b0, 1'b1, 1'b1, "R9 first");
        chk("R9 bus_a", bus_a, PAT_A[0]);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule